// File: doc/BRIEF.md
# Function-Level Image Filter Element with Absolute-Difference Fitness

This block pairs an 8-bit processing element with a fitness accumulator. Together they form one evaluation slice of an evolved image filter. The processing element takes two pixel operands and applies one of eight operations picked by a 3-bit code: three bitwise operations, a wrapping add, a clamping add, a halving average, and a larger-of and smaller-of selection. The result is registered, so it appears one clock edge after the operands.

The accumulator scores a candidate filter. It takes a stream of filtered pixels, each paired with the matching pixel of a clean reference image, and sums the absolute difference of every valid pair over a 128 by 128 frame. A lower total means a better filter. A frame-start pulse clears the total. Once the last pixel of the frame has been added, a done flag rises. The total then stays frozen until the next frame start, so the search logic outside can read it at leisure.

Top module: `evo_filter_fitness`

## Requirements
- R1: Function code 0 gives a OR b, code 1 gives a AND b, and code 2 gives a XOR b.
- R2: Function code 3 gives a + b, keeping only the low 8 bits.
- R3: Function code 4 gives a + b clamped to 255 when the true sum exceeds 255.
- R4: Function code 5 gives (a + b) >> 1, computed from the full 9-bit sum so the carry is kept.
- R5: Function code 6 gives the larger operand, and code 7 gives the smaller.
- R6: pe_result is registered. It shows the function of the operands and code sampled at the previous rising edge.
- R7: Each cycle with pix_valid high adds |pix_filt − pix_ref| to fitness at that edge. Cycles with pix_valid low leave fitness unchanged.
- R8: frame_start sets fitness to 0 and fit_done to 0. If pix_valid is high in the same cycle, that pixel counts as the first pixel of the new frame, and fitness becomes its difference.
- R9: fit_done rises at the edge that accumulates the 16384th valid pixel since frame start. It is low before that edge.
- R10: While fit_done is high and frame_start is low, fitness and fit_done hold their values, and any valid pixels are ignored.
- R11: fitness is 22 bits wide and reaches the full-scale total 255 × 16384 = 4177920 without wrapping.
- R12: While rst_n is low, pe_result, fitness and fit_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 8 | First pixel operand |
| op_b | input | 8 | Second pixel operand |
| func_sel | input | 3 | Operation code, 0 to 7 |
| pe_result | output | 8 | Registered operation result |
| frame_start | input | 1 | Clears the fitness total and begins a frame |
| pix_valid | input | 1 | Qualifies pix_filt and pix_ref |
| pix_filt | input | 8 | Filtered pixel |
| pix_ref | input | 8 | Reference pixel |
| fitness | output | 22 | Accumulated sum of absolute differences |
| fit_done | output | 1 | Frame total complete |

## Verification
Two events can fall in the same cycle: a frame start and a valid pixel. The bench raises frame_start together with the first pixel of a new frame, right after the previous frame has completed. It then expects the total to equal that single pixel's difference rather than zero, and it expects the frame to finish exactly 16384 pixels later. A second overlap occurs when valid pixels keep arriving after completion. The bench expects these pixels to leave the frozen total and the done flag untouched.

// File: rtl/evo_pkg.sv
package evo_pkg;
  typedef enum logic [2:0] {
    FN_OR   = 3'd0,
    FN_AND  = 3'd1,
    FN_XOR  = 3'd2,
    FN_ADD  = 3'd3,
    FN_SADD = 3'd4,
    FN_AVG  = 3'd5,
    FN_MAX  = 3'd6,
    FN_MIN  = 3'd7
  } fn_e;
endpackage

// File: rtl/evo_pe_fn.sv
module evo_pe_fn #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   fn_sel,
  output logic [W-1:0] y
);
  import evo_pkg::*;

  logic [W:0] sum_w;   // carry-preserving sum
  logic       a_ge_b;

  assign sum_w  = {1'b0, a} + {1'b0, b};
  assign a_ge_b = (a >= b);

  always_comb begin
    unique case (fn_e'(fn_sel))
      FN_OR:   y = a | b;
      FN_AND:  y = a & b;
      FN_XOR:  y = a ^ b;
      FN_ADD:  y = sum_w[W-1:0];
      FN_SADD: y = sum_w[W] ? {W{1'b1}} : sum_w[W-1:0];
      FN_AVG:  y = sum_w[W:1];
      FN_MAX:  y = a_ge_b ? a : b;
      FN_MIN:  y = a_ge_b ? b : a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/evo_absdiff.sv
module evo_absdiff #(
  parameter int W = 8
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] q,
  output logic [W-1:0] d
);
  always_comb begin
    if (p >= q) d = p - q;
    else        d = q - p;
  end
endmodule

// File: rtl/evo_sad_acc.sv
module evo_sad_acc #(
  parameter int W     = 8,
  parameter int DIM   = 128,
  parameter int ACC_W = W + $clog2(DIM * DIM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             valid,
  input  logic [W-1:0]     diff,
  output logic [ACC_W-1:0] total,
  output logic             done
);
  localparam int NPIX  = DIM * DIM;
  localparam int CNT_W = (NPIX > 1) ? $clog2(NPIX) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NPIX - 1);

  logic [ACC_W-1:0] acc_q, acc_d, acc_base;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
  logic             done_q, done_d, done_base;
  logic             take, en;

  // next-state
  always_comb begin
    acc_base  = frame_start ? '0   : acc_q;
    cnt_base  = frame_start ? '0   : cnt_q;
    done_base = frame_start ? 1'b0 : done_q;
    take      = valid && !done_base;
    en        = frame_start || take;
    acc_d     = acc_base;
    cnt_d     = cnt_base;
    done_d    = done_base;
    if (take) begin
      acc_d = acc_base + ACC_W'(diff);
      if (cnt_base == LAST) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d  = cnt_base + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (en) begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign total = acc_q;
  assign done  = done_q;

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !valid) |=> (total == '0 && !done));

  a_r10_done_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !frame_start) |=> (done && $stable(total)));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !frame_start) |=> $stable(total));

  a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (total >= $past(total)));
endmodule

// File: rtl/evo_filter_fitness.sv
module evo_filter_fitness #(
  parameter int PIX_W   = 8,
  parameter int IMG_DIM = 128,
  parameter int ACC_W   = PIX_W + $clog2(IMG_DIM * IMG_DIM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] op_a,
  input  logic [PIX_W-1:0] op_b,
  input  logic [2:0]       func_sel,
  output logic [PIX_W-1:0] pe_result,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_filt,
  input  logic [PIX_W-1:0] pix_ref,
  output logic [ACC_W-1:0] fitness,
  output logic             fit_done
);
  import evo_pkg::*;

  logic [PIX_W-1:0] fn_y;
  logic [PIX_W-1:0] pe_q, pe_d;
  logic [PIX_W-1:0] pix_diff;

  evo_pe_fn #(.W(PIX_W)) u_fn (
    .a(op_a), .b(op_b), .fn_sel(func_sel), .y(fn_y)
  );

  assign pe_d = fn_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pe_q <= '0;
    else        pe_q <= pe_d;
  end

  assign pe_result = pe_q;

  evo_absdiff #(.W(PIX_W)) u_diff (
    .p(pix_filt), .q(pix_ref), .d(pix_diff)
  );

  evo_sad_acc #(.W(PIX_W), .DIM(IMG_DIM), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .valid(pix_valid), .diff(pix_diff), .total(fitness), .done(fit_done)
  );

  a_r3_sat_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (func_sel == FN_SADD) |=> (pe_result >= $past(op_a) && pe_result >= $past(op_b)));

  a_r5_max_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (func_sel == FN_MAX) |=> (pe_result >= $past(op_a) && pe_result >= $past(op_b)));

  a_r4_avg_between: assert property (@(posedge clk) disable iff (!rst_n)
    (func_sel == FN_AVG) |=>
      (($past(op_a) <= $past(op_b)) ?
        (pe_result >= $past(op_a) && pe_result <= $past(op_b)) :
        (pe_result >= $past(op_b) && pe_result <= $past(op_a))));
endmodule

// File: tb/evo_filter_fitness_tb.sv
module evo_filter_fitness_tb;
  localparam int NPIX = 128 * 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  op_a, op_b;
  logic [2:0]  func_sel;
  logic [7:0]  pe_result;
  logic        frame_start, pix_valid;
  logic [7:0]  pix_filt, pix_ref;
  logic [21:0] fitness;
  logic        fit_done;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] exp; logic [2:0] fn; } pe_item_t;
  pe_item_t pe_q[$];

  always #4 clk = ~clk;

  evo_filter_fitness u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .func_sel(func_sel),
    .pe_result(pe_result), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_filt(pix_filt), .pix_ref(pix_ref), .fitness(fitness), .fit_done(fit_done)
  );

  function automatic string fn_req(input logic [2:0] f);
    case (f)
      3'd0, 3'd1, 3'd2: return "R1";
      3'd3: return "R2";
      3'd4: return "R3";
      3'd5: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [7:0] model(input logic [2:0] f, input logic [7:0] a, input logic [7:0] b);
    int s;
    s = int'(a) + int'(b);
    case (f)
      3'd0: return a | b;
      3'd1: return a & b;
      3'd2: return a ^ b;
      3'd3: return 8'(s % 256);
      3'd4: return (s > 255) ? 8'd255 : 8'(s);
      3'd5: return 8'(s / 2);
      3'd6: return (a > b) ? a : b;
      default: return (a < b) ? a : b;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: drives operands at the falling edge and queues the expected result
  task automatic pe_drive(input logic [2:0] f, input logic [7:0] a, input logic [7:0] b);
    pe_item_t it;
    @(negedge clk);
    op_a = a; op_b = b; func_sel = f;
    it.exp = model(f, a, b); it.fn = f;
    pe_q.push_back(it);
  endtask

  // monitor: 2 ns after each rising edge the registered result (R6) is compared
  always @(posedge clk) begin
    #2;
    if (pe_q.size() > 0) begin
      pe_item_t it;
      it = pe_q.pop_front();
      check(pe_result == it.exp, {fn_req(it.fn), "/R6"}, pe_result, it.exp);
    end
  end

  task automatic pix(input bit st, input bit v, input logic [7:0] f, input logic [7:0] r);
    @(negedge clk);
    frame_start = st; pix_valid = v; pix_filt = f; pix_ref = r;
  endtask

  // runs one frame; mode 1 uses maximal differences; joint puts frame_start on pixel 0
  task automatic run_frame(input int mode, input bit joint);
    longint expsum = 0;
    logic [7:0] f, r;
    if (!joint) begin
      pix(1'b1, 1'b0, 8'd0, 8'd0);
      @(negedge clk);
      frame_start = 1'b0;
      check(fitness == 0 && !fit_done, "R8", fitness, 0);
    end
    for (int i = 0; i < NPIX; i++) begin
      if (mode == 1) begin
        f = (i % 2 == 0) ? 8'd255 : 8'd0; r = ~f;
      end else begin
        f = 8'($urandom); r = 8'($urandom);
      end
      if (i % 7 == 3) pix(1'b0, 1'b0, 8'd99, 8'd1);  // idle gap
      if (i == NPIX - 1) check(!fit_done, "R9", fit_done, 0);
      pix(joint && i == 0, 1'b1, f, r);
      expsum += (f > r) ? (f - r) : (r - f);
      if (i == 0 && joint) begin
        @(negedge clk);
        frame_start = 1'b0; pix_valid = 1'b0;
        check(fitness == 22'(expsum) && !fit_done, "R8", fitness, int'(expsum));
      end
      if (i == 5) begin
        @(negedge clk);
        pix_valid = 1'b0;
        check(fitness == 22'(expsum), "R7", fitness, int'(expsum));
        @(negedge clk);
        check(fitness == 22'(expsum), "R7", fitness, int'(expsum));
      end
    end
    @(negedge clk);
    pix_valid = 1'b0;
    check(fit_done, "R9", fit_done, 1);
    check(fitness == 22'(expsum), mode == 1 ? "R11" : "R7", fitness, int'(expsum));
    for (int k = 0; k < 3; k++) pix(1'b0, 1'b1, 8'd200, 8'd0);
    @(negedge clk);
    pix_valid = 1'b0;
    check(fit_done && fitness == 22'(expsum), "R10", fitness, int'(expsum));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; func_sel = '0;
    frame_start = 1'b0; pix_valid = 1'b0; pix_filt = '0; pix_ref = '0;
    repeat (3) @(negedge clk);
    op_a = 8'd77; op_b = 8'd12; pix_valid = 1'b1; pix_filt = 8'd9;
    @(negedge clk);
    check(pe_result == 0 && fitness == 0 && !fit_done, "R12", pe_result, 0);
    pix_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int f = 0; f < 8; f++) begin
      pe_drive(3'(f), 8'd0,   8'd0);
      pe_drive(3'(f), 8'd255, 8'd255);
      pe_drive(3'(f), 8'd255, 8'd0);
      pe_drive(3'(f), 8'd0,   8'd255);
      pe_drive(3'(f), 8'd90,  8'd90);
      pe_drive(3'(f), 8'd200, 8'd100);
      pe_drive(3'(f), 8'd37,  8'd171);
      pe_drive(3'(f), 8'd129, 8'd128);
    end
    pe_drive(3'd4, 8'd128, 8'd127);  // R3 just under the clamp
    pe_drive(3'd5, 8'd255, 8'd253);  // R4 carry kept
    @(negedge clk);
    @(negedge clk);

    run_frame(0, 1'b0);
    run_frame(0, 1'b1);
    run_frame(1, 1'b0);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule